// File: doc/BRIEF.md
# Shared-Line Interrupt Steering Router

The router takes eight level-sensitive interrupt request inputs, one per link (links A to H), and steers each one onto one line of a sixteen-line IRQ output vector. Every link has its own 8-bit steering register. The register holds an off flag and a 4-bit target line number. A link drives its target line only when the flag is clear and the target is in the fixed set of legal lines. If a register names a reserved line, the link behaves exactly as if it were switched off.

Several links may name the same line, and that line is then the OR of every valid, active link routed to it. Each request input is already the OR of all sources sharing that link, so a link stays active until its last source lets go. Software rewrites a steering register over a small synchronous register bus. When it does, a live request moves from the old line to the new one with no cycle where both lines are high. The same bus also gives a per-link status code that shows whether the link is usable.

Top module: `intx_irq_router`

## Requirements
- R1: Steering registers sit at bus addresses 0 to 7, where address bit 3 is 0 and bits 2:0 give the link (0 = link A … 7 = link H). A write with `regWe` high is stored at the clock edge. `regRdata` shows the addressed register combinationally.
- R2: Only bit 7 (the off flag) and bits 3:0 (the target line) are stored. Bits 6:4 of a written value are dropped and always read back as zero.
- R3: While synchronous reset `rst` is high, every steering register becomes 0x80 and `irqOut` becomes all zero.
- R4: A target line n is legal only when bit n of the mask 0xDEF8 is set. The legal lines are 3–7, 9–12, 14 and 15. Output lines 0, 1, 2, 8 and 13 never go high.
- R5: A link is valid only when bit 7 is 0 and its target line is legal. A link that is off, or that names a reserved line, drives no output even while its request is high.
- R6: `irqOut[n]` is the OR of every valid link whose request is high and whose target is n. It is registered, so it follows a request or register change at the next clock edge.
- R7: Rewriting a register while its link is active moves the assertion. One edge after the write, the old line is released (if nothing else holds it) and the new line is driven (if valid), in the same cycle. A write of the value already stored changes nothing.
- R8: Reading address 8+k returns link k's status: 0x0B when the link is valid and 0x09 when it is not.
- R9: Writes to status addresses 8 to 15 have no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | 4 | Bus address: bit 3 selects status space, bits 2:0 select the link |
| regWe | input | 1 | Write enable |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data (combinational) |
| pinReq | input | 8 | Level request per link, bit k = link k |
| irqOut | output | 16 | Registered IRQ line vector |

## Verification
On every cycle, the assertions check these things:
- Reserved lines stay low.
- The unused register bits stay zero.
- A load strobe lands its value.
- A register holds when no strobe is issued.
- Status writes produce no strobe.
- Status reads return only one of the two codes.
- No output is high one cycle after all requests are low.

Some behaviour only the bench's scenarios can show:
- The exact line chosen for each target.
- Sharing and release order on a common line.
- The same-cycle move from old to new line on a rewrite.
- That an identical rewrite leaves the outputs untouched.

The bench shows these by comparing against a behavioural model every cycle and by checks at hand-chosen cycles.

// File: rtl/intx_router_pkg.sv
package intx_router_pkg;
  localparam int NUM_PINS = 8;
  localparam int NUM_IRQS = 16;
  localparam int REG_W    = 8;
  localparam int PIN_W    = $clog2(NUM_PINS);
  localparam int ADDR_W   = PIN_W + 1;
  localparam int IRQ_W    = $clog2(NUM_IRQS);
  localparam int OFF_BIT  = REG_W - 1;

  localparam logic [REG_W-1:0] KEEP_MASK   = 8'h8F;
  localparam logic [REG_W-1:0] RESET_VAL   = 8'h80;
  localparam logic [REG_W-1:0] STAT_GOOD   = 8'h0B;
  localparam logic [REG_W-1:0] STAT_BAD    = 8'h09;

  typedef struct packed {
    logic [NUM_PINS-1:0] load;
    logic [REG_W-1:0]    value;
  } routeStrobe_t;
endpackage

// File: rtl/intx_router_ctrl.sv
module intx_router_ctrl
  import intx_router_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst,
  input  logic [ADDR_W-1:0]                regAddr,
  input  logic                             regWe,
  input  logic [REG_W-1:0]                 regWdata,
  input  logic [NUM_PINS-1:0][REG_W-1:0]   curRegs,
  output routeStrobe_t                     strobe,
  output logic                             statusSel,
  output logic [PIN_W-1:0]                 pinSel
);
  logic routeSpace;
  logic [REG_W-1:0] maskedData;

  assign statusSel  = regAddr[ADDR_W-1];
  assign routeSpace = ~regAddr[ADDR_W-1];
  assign pinSel     = regAddr[PIN_W-1:0];
  assign maskedData = regWdata & KEEP_MASK;
  assign strobe.value = maskedData;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_load
    logic hit;
    assign hit = regWe && routeSpace && (pinSel == PIN_W'(p));
    // only issue a load when the stored value would actually change
    assign strobe.load[p] = hit && (curRegs[p] != maskedData);
  end

  p_single_load_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe.load));

  p_status_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (regWe && regAddr[ADDR_W-1]) |-> (strobe.load == '0));
endmodule

// File: rtl/intx_router_dp.sv
module intx_router_dp
  import intx_router_pkg::*;
#(
  parameter logic [NUM_IRQS-1:0] LEGAL_MASK = 16'hDEF8
)(
  input  logic                             clk,
  input  logic                             rst,
  input  routeStrobe_t                     strobe,
  input  logic [NUM_PINS-1:0]              pinReq,
  input  logic                             statusSel,
  input  logic [PIN_W-1:0]                 pinSel,
  output logic [NUM_PINS-1:0][REG_W-1:0]   routeRegs,
  output logic [REG_W-1:0]                 regRdata,
  output logic [NUM_IRQS-1:0]              irqOut
);
  logic [NUM_PINS-1:0]               pinValid;
  logic [NUM_PINS-1:0][NUM_IRQS-1:0] steer;
  logic [NUM_IRQS-1:0]               merged;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [IRQ_W-1:0] target;

    always_ff @(posedge clk) begin
      if (rst)                 routeRegs[p] <= RESET_VAL;
      else if (strobe.load[p]) routeRegs[p] <= strobe.value;
    end

    assign target      = routeRegs[p][IRQ_W-1:0];
    assign pinValid[p] = ~routeRegs[p][OFF_BIT] && LEGAL_MASK[target];

    always_comb begin
      steer[p] = '0;
      if (pinValid[p] && pinReq[p]) steer[p][target] = 1'b1;
    end

    p_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
      (routeRegs[p] & ~KEEP_MASK) == '0);

    p_load_lands_r7: assert property (@(posedge clk) disable iff (rst)
      strobe.load[p] |=> (routeRegs[p] == $past(strobe.value)));

    p_hold_without_load_r9: assert property (@(posedge clk) disable iff (rst)
      !strobe.load[p] |=> $stable(routeRegs[p]));
  end

  always_comb begin
    merged = '0;
    for (int p = 0; p < NUM_PINS; p++) merged = merged | steer[p];
  end

  always_ff @(posedge clk) begin
    if (rst) irqOut <= '0;
    else     irqOut <= merged;
  end

  always_comb begin
    if (statusSel) regRdata = pinValid[pinSel] ? STAT_GOOD : STAT_BAD;
    else           regRdata = routeRegs[pinSel];
  end

  p_reset_state_r3: assert property (@(posedge clk)
    rst |=> (irqOut == '0 && routeRegs[0] == RESET_VAL && routeRegs[NUM_PINS-1] == RESET_VAL));

  p_reserved_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (irqOut & ~LEGAL_MASK) == '0);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (pinReq == '0) |=> (irqOut == '0));
endmodule

// File: rtl/intx_irq_router.sv
module intx_irq_router
  import intx_router_pkg::*;
#(
  parameter logic [15:0] LEGAL_MASK = 16'hDEF8
)(
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  regAddr,
  input  logic        regWe,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  logic [7:0]  pinReq,
  output logic [15:0] irqOut
);
  routeStrobe_t                   strobe;
  logic                           statusSel;
  logic [PIN_W-1:0]               pinSel;
  logic [NUM_PINS-1:0][REG_W-1:0] routeRegs;

  intx_router_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .regAddr   (regAddr),
    .regWe     (regWe),
    .regWdata  (regWdata),
    .curRegs   (routeRegs),
    .strobe    (strobe),
    .statusSel (statusSel),
    .pinSel    (pinSel)
  );

  intx_router_dp #(.LEGAL_MASK(LEGAL_MASK)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .pinReq    (pinReq),
    .statusSel (statusSel),
    .pinSel    (pinSel),
    .routeRegs (routeRegs),
    .regRdata  (regRdata),
    .irqOut    (irqOut)
  );

  p_status_code_r8: assert property (@(posedge clk) disable iff (rst)
    regAddr[3] |-> (regRdata == STAT_GOOD || regRdata == STAT_BAD));
endmodule

// File: tb/intx_irq_router_bench.sv
module intx_irq_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wd = '0;
  logic [7:0]  req = '0;
  logic [7:0]  regRdata;
  logic [15:0] irqOut;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit modelLive = 0;

  logic [7:0]  mreg [8];
  logic [15:0] expIrq = '0;

  always #5 clk = ~clk;

  intx_irq_router u_intx_irq_router (
    .clk(clk), .rst(rst), .regAddr(addr), .regWe(we), .regWdata(wd),
    .regRdata(regRdata), .pinReq(req), .irqOut(irqOut)
  );

  function automatic bit legalLine(input int n);
    return ((16'hDEF8 >> n) & 16'h1) != 0;
  endfunction

  function automatic bit linkOk(input logic [7:0] v);
    return !v[7] && legalLine(int'(v[3:0]));
  endfunction

  // behavioural reference: output from pre-edge state, then apply write
  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 8; k++) mreg[k] = 8'h80;
      expIrq = '0;
      modelLive = 1;
    end else begin
      logic [15:0] acc;
      acc = '0;
      for (int k = 0; k < 8; k++)
        if (req[k] && linkOk(mreg[k])) acc[mreg[k][3:0]] = 1'b1;
      expIrq = acc;
      if (we && !addr[3]) mreg[addr[2:0]] = wd & 8'h8F;
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=50000", cycles);
      report();
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [7:0] expRd;
    @(negedge clk);
    if (modelLive && !rst) begin
      chk("R6 model irqOut", int'(irqOut), int'(expIrq));
      if (addr[3]) expRd = linkOk(mreg[addr[2:0]]) ? 8'h0B : 8'h09;
      else         expRd = mreg[addr[2:0]];
      chk("R1 model regRdata", int'(regRdata), int'(expRd));
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    tick(); addr = a; we = 1'b1; wd = d;
    tick(); we = 1'b0;
  endtask

  task automatic setReq(input logic [7:0] v);
    tick(); req = v;
  endtask

  task automatic expectIrq(input string tag, input logic [15:0] e);
    tick(); tick();
    chk(tag, int'(irqOut), int'(e));
  endtask

  task automatic peek(input string tag, input logic [3:0] a, input logic [7:0] e);
    tick(); addr = a;
    tick();
    chk(tag, int'(regRdata), int'(e));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R3 reset values, R8 status after reset
    for (int k = 0; k < 8; k++) peek("R3 reset reg", 4'(k), 8'h80);
    chk("R3 reset irqOut", int'(irqOut), 0);
    peek("R8 status invalid after reset", 4'd8, 8'h09);

    // R2 dropped bits
    wr(4'd0, 8'h75);
    peek("R2 unused bits dropped", 4'd0, 8'h05);
    peek("R8 status valid", 4'd8, 8'h0B);

    // R6 basic steering and sharing
    setReq(8'h01);
    expectIrq("R6 link A to line 5", 16'h0020);
    wr(4'd1, 8'h05);
    setReq(8'h03);
    expectIrq("R6 shared line 5", 16'h0020);
    setReq(8'h02);
    expectIrq("R6 shared line held by B", 16'h0020);
    setReq(8'h00);
    expectIrq("R6 last release clears", 16'h0000);

    // R5 reserved targets and off flag
    setReq(8'h04);
    for (int n = 0; n < 4; n++) begin
      logic [7:0] bad;
      bad = (n == 0) ? 8'h08 : (n == 1) ? 8'h0D : (n == 2) ? 8'h00 : 8'h02;
      wr(4'd2, bad);
      expectIrq("R5 reserved target silent", 16'h0000);
      peek("R8 reserved target status", 4'd10, 8'h09);
    end
    wr(4'd2, 8'h83);
    expectIrq("R5 off flag silent", 16'h0000);
    peek("R8 off link status", 4'd10, 8'h09);
    setReq(8'h00);

    // R7 re-steer moves live assertion in one cycle
    wr(4'd3, 8'h03);
    setReq(8'h08);
    expectIrq("R7 before move", 16'h0008);
    wr(4'd3, 8'h0F);
    chk("R7 old line still registered", int'(irqOut), 16'h0008);
    tick();
    chk("R7 moved in same cycle", int'(irqOut), 16'h8000);
    wr(4'd3, 8'h0F);
    expectIrq("R7 identical rewrite no effect", 16'h8000);
    wr(4'd3, 8'h0D);
    expectIrq("R7 move to reserved releases", 16'h0000);
    setReq(8'h00);

    // R9 status writes ignored
    wr(4'd9, 8'h0E);
    peek("R9 status write ignored", 4'd1, 8'h05);

    // R4 sweep of every target line
    setReq(8'h10);
    for (int n = 0; n < 16; n++) begin
      wr(4'd4, 8'(n));
      expectIrq("R4 legal line sweep",
                legalLine(n) ? (16'h1 << n) : 16'h0000);
    end
    setReq(8'h00);

    // R3 mid-run reset
    wr(4'd5, 8'h0A);
    setReq(8'h20);
    expectIrq("R6 link F line 10", 16'h0400);
    tick(); rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    peek("R3 reset clears reg", 4'd5, 8'h80);
    chk("R3 reset clears irqOut", int'(irqOut), 0);
    setReq(8'h00);
    repeat (3) tick();

    report();
    $finish;
  end
endmodule